// File: doc/BRIEF.md
# Prescaled Compare Timer

This block is an up-counting timer that sits behind a small word-indexed register port. A control register picks one of three tick-enable inputs and the counting mode. A 12-bit prescaler divides the selected tick, and each divided tick steps the counter by one. Three compare registers are checked against the counter on every step. Each match sets a sticky status flag, and a wrap from all-ones to zero sets a rollover flag. An enable mask routes the status flags onto one level interrupt line.

Software chooses between two modes. In free-run mode the counter runs through its full range. In restart mode compare channel 1 acts as the period: after the counter reaches it, the next step returns the counter to zero. Software can reset the timer by setting a control bit. That reset returns the register file to its reset values but keeps the clock-source, mode and upper control bits.

Top module: `cmpTimer`

## Requirements
- R1: Word indices are fixed: 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4/5/6 compare 1/2/3, 7/8 capture 1/2, 9 counter. The capture registers always read zero and ignore writes. Indices 10 to 15 read zero and a write to them changes nothing.
- R2: Control bits 8:6 select the tick: 3'b001 selects `tickPeriph`, 3'b010 selects `tickHigh` and 3'b100 selects `tickSlow`. Any other code selects no tick, and the counter holds its value.
- R3: The prescaler keeps only bits 11:0. While the timer is enabled (control bit 0), the counter steps once per (prescaler + 1) selected ticks.
- R4: Status bit i (i = 0..2) is the compare i+1 flag, bit 5 is rollover, and bits 3 and 4 always read zero. A status write clears each low-6 bit written as 1 and leaves every other flag set.
- R5: The interrupt enable keeps only bits 5:0. `irqOut` is high exactly when control bit 0 is set and (status AND enable) is nonzero.
- R6: A compare flag is set on the same clock edge at which the counter steps to a value equal to that compare register, and not before.
- R7: With control bit 9 set (free-run), the counter wraps from all-ones to zero, and that step sets status bit 5.
- R8: With control bit 9 clear (restart), the step taken while the counter equals compare 1 returns the counter to zero, and no rollover flag is set unless compare 1 is all-ones.
- R9: In restart mode a write to compare 1 clears the counter and the prescaler phase. In free-run mode such a write leaves the counter unchanged.
- R10: When a control write sets bit 0 while it was clear, with bit 1 (enable-mode) also set, the counter and prescaler phase clear. Without bit 1 the count resumes from its held value. While bit 0 is clear the counter holds.
- R11: Control bits 2, 4 and 10 to 14 always read zero. Bit 15 (soft reset) always reads zero.
- R12: A control write with bit 15 set stores the written value with bits 0, 1, 3, 5 and 15 cleared. It also zeroes prescaler, status, interrupt enable and counter, and sets all compares to all-ones. A hardware reset gives the same values with control all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous hardware reset |
| tickPeriph | input | 1 | Tick enable, source code 3'b001 |
| tickHigh | input | 1 | Tick enable, source code 3'b010 |
| tickSlow | input | 1 | Tick enable, source code 3'b100 |
| busSel | input | 1 | Register access select |
| busWrite | input | 1 | Write strobe, sampled with busSel |
| busAddr | input | 4 | Word index of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| irqOut | output | 1 | Level interrupt |

## Verification
A register write takes effect on the clock edge that samples it, so its readback is due at the falling edge that follows. A tick is sampled on one rising edge. The counter, the status flags it sets and `irqOut` (decoded combinationally from stored state) all change on that same edge, with no extra pipeline cycle. The bench drives every input at a falling edge and samples at the next falling edge, which means every expected value is compared exactly one edge after its cause. The boundary checks sample the counter one step before a compare value and again at it, to confirm that each flag rises on the matching edge and not earlier.

// File: rtl/cmpTimerPkg.sv
package cmpTimerPkg;

  localparam int REG_IDX_W = 4;
  localparam int BUS_W     = 32;
  localparam int PRESC_W   = 12;
  localparam int STAT_W    = 6;
  localparam int NUM_CMP   = 3;

  typedef logic [REG_IDX_W-1:0] regIdx_t;

  localparam regIdx_t REG_CTRL  = 4'd0;
  localparam regIdx_t REG_PRESC = 4'd1;
  localparam regIdx_t REG_STAT  = 4'd2;
  localparam regIdx_t REG_IEN   = 4'd3;
  localparam regIdx_t REG_CMP1  = 4'd4;
  localparam regIdx_t REG_CAP1  = 4'd7;
  localparam regIdx_t REG_CAP2  = 4'd8;
  localparam regIdx_t REG_COUNT = 4'd9;

  // control bit positions
  localparam int CB_EN     = 0;
  localparam int CB_ENMOD  = 1;
  localparam int CB_WAIT   = 3;
  localparam int CB_STOP   = 5;
  localparam int CB_SRC_LO = 6;
  localparam int CB_FREE   = 9;
  localparam int CB_SWR    = 15;

  localparam logic [2:0] SRC_PERIPH = 3'b001;
  localparam logic [2:0] SRC_HIGH   = 3'b010;
  localparam logic [2:0] SRC_SLOW   = 3'b100;

  // status bit of the rollover flag; compare i uses bit i
  localparam int SB_ROLL = 5;

  localparam logic [BUS_W-1:0] CTRL_ZERO_MASK = 32'h0000_7C14;
  localparam logic [BUS_W-1:0] CTRL_RST_CLR =
      (32'd1 << CB_EN) | (32'd1 << CB_ENMOD) | (32'd1 << CB_WAIT) |
      (32'd1 << CB_STOP) | (32'd1 << CB_SWR) | CTRL_ZERO_MASK;

  typedef struct packed {
    logic clearCount;  // restart counter and prescaler phase
    logic countTick;   // enabled and selected tick present
    logic freeRun;     // 1: full-range wrap, 0: compare 1 is the period
  } dpStrobes_t;

endpackage

// File: rtl/cmpTimerCtrl.sv
module cmpTimerCtrl
  import cmpTimerPkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           tickPeriph,
  input  logic                           tickHigh,
  input  logic                           tickSlow,
  input  logic                           busSel,
  input  logic                           busWrite,
  input  regIdx_t                        busAddr,
  input  logic [BUS_W-1:0]               busWdata,
  output logic [BUS_W-1:0]               busRdata,
  output logic                           irqOut,
  output dpStrobes_t                     strb,
  output logic [PRESC_W-1:0]             prescaleVal,
  output logic [NUM_CMP-1:0][CNT_W-1:0]  cmpVals,
  input  logic [NUM_CMP-1:0]             cmpHit,
  input  logic                           rollHit,
  input  logic [CNT_W-1:0]               countVal
);

  logic [BUS_W-1:0]   ctrlReg;
  logic [PRESC_W-1:0] prescReg;
  logic [STAT_W-1:0]  statusReg;
  logic [STAT_W-1:0]  ienReg;
  logic [STAT_W-1:0]  statusSet;
  logic [STAT_W-1:0]  statusClr;
  logic [STAT_W-1:0]  statusNext;
  logic [BUS_W-1:0]   ctrlMasked;
  logic [2:0]         srcCode;
  logic               selTick;
  logic               wrEn, wrCtrl, wrPresc, wrStat, wrIen;
  logic               swReset, enRise, cmp1Restart;
  logic [NUM_CMP-1:0] wrCmp;

  assign wrEn    = busSel & busWrite;
  assign wrCtrl  = wrEn && (busAddr == REG_CTRL);
  assign wrPresc = wrEn && (busAddr == REG_PRESC);
  assign wrStat  = wrEn && (busAddr == REG_STAT);
  assign wrIen   = wrEn && (busAddr == REG_IEN);

  assign ctrlMasked = busWdata & ~CTRL_ZERO_MASK;
  assign swReset    = wrCtrl && ctrlMasked[CB_SWR];
  assign enRise     = wrCtrl && !swReset && !ctrlReg[CB_EN] &&
                      ctrlMasked[CB_EN] && ctrlMasked[CB_ENMOD];
  assign cmp1Restart = wrCmp[0] && !ctrlReg[CB_FREE];

  // tick source selection
  assign srcCode = ctrlReg[CB_SRC_LO +: 3];
  always_comb begin
    case (srcCode)
      SRC_PERIPH: selTick = tickPeriph;
      SRC_HIGH:   selTick = tickHigh;
      SRC_SLOW:   selTick = tickSlow;
      default:    selTick = 1'b0;
    endcase
  end

  assign strb.clearCount = swReset | enRise | cmp1Restart;
  assign strb.countTick  = ctrlReg[CB_EN] & selTick;
  assign strb.freeRun    = ctrlReg[CB_FREE];
  assign prescaleVal     = prescReg;

  // status flags: set by datapath events, cleared by writing ones
  always_comb begin
    statusSet = '0;
    statusSet[NUM_CMP-1:0] = cmpHit;
    statusSet[SB_ROLL]     = rollHit;
    statusClr  = wrStat ? busWdata[STAT_W-1:0] : '0;
    statusNext = (statusReg & ~statusClr) | statusSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      prescReg  <= '0;
      statusReg <= '0;
      ienReg    <= '0;
    end else if (swReset) begin
      ctrlReg   <= ctrlMasked & ~CTRL_RST_CLR;
      prescReg  <= '0;
      statusReg <= '0;
      ienReg    <= '0;
    end else begin
      if (wrCtrl)  ctrlReg  <= ctrlMasked & ~(32'd1 << CB_SWR);
      if (wrPresc) prescReg <= busWdata[PRESC_W-1:0];
      if (wrIen)   ienReg   <= busWdata[STAT_W-1:0];
      statusReg <= statusNext;
    end
  end

  // compare registers
  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
    assign wrCmp[gi] = wrEn && (busAddr == regIdx_t'(REG_CMP1 + gi));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          cmpVals[gi] <= '1;
      else if (swReset)   cmpVals[gi] <= '1;
      else if (wrCmp[gi]) cmpVals[gi] <= busWdata[CNT_W-1:0];
    end
  end

  // read mux
  always_comb begin
    busRdata = '0;
    case (busAddr)
      REG_CTRL:  busRdata = ctrlReg;
      REG_PRESC: busRdata = BUS_W'(prescReg);
      REG_STAT:  busRdata = BUS_W'(statusReg);
      REG_IEN:   busRdata = BUS_W'(ienReg);
      REG_CAP1:  busRdata = '0;
      REG_CAP2:  busRdata = '0;
      REG_COUNT: busRdata = BUS_W'(countVal);
      default: begin
        for (int i = 0; i < NUM_CMP; i++) begin
          if (busAddr == regIdx_t'(REG_CMP1 + i)) busRdata = BUS_W'(cmpVals[i]);
        end
      end
    endcase
  end

  assign irqOut = ctrlReg[CB_EN] && |(statusReg & ienReg);

  // R4: a flag stays set unless a status write or soft reset intervenes
  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!wrStat && !swReset) |=> ((statusReg & $past(statusReg)) == $past(statusReg)));

  // R5: interrupt only while enabled
  p_irq_needs_en_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ctrlReg[CB_EN]);

  // R12: soft reset leaves status, enable mask and enable cleared
  p_swr_clears_r12: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> (statusReg == '0 && ienReg == '0 && !ctrlReg[CB_EN] && prescReg == '0));

  // R11: soft-reset bit never reads back
  p_swr_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> !busRdata[CB_SWR] || busAddr != REG_CTRL);

endmodule

// File: rtl/cmpTimerDatapath.sv
module cmpTimerDatapath
  import cmpTimerPkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dpStrobes_t                     strb,
  input  logic [PRESC_W-1:0]             prescaleVal,
  input  logic [NUM_CMP-1:0][CNT_W-1:0]  cmpVals,
  output logic [CNT_W-1:0]               countVal,
  output logic [NUM_CMP-1:0]             cmpHit,
  output logic                           rollHit
);

  logic [CNT_W-1:0]   countReg;
  logic [CNT_W-1:0]   countNext;
  logic [PRESC_W-1:0] psPhase;
  logic               step;
  logic               periodEnd;

  assign step      = strb.countTick && !strb.clearCount && (psPhase >= prescaleVal);
  assign periodEnd = !strb.freeRun && (countReg == cmpVals[0]);
  assign countNext = periodEnd ? '0 : countReg + 1'b1;
  assign rollHit   = step && (countReg == '1);

  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_hit
    assign cmpHit[gi] = step && (countNext == cmpVals[gi]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psPhase <= '0;
    end else if (strb.clearCount) begin
      psPhase <= '0;
    end else if (strb.countTick) begin
      psPhase <= step ? '0 : psPhase + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                countReg <= '0;
    else if (strb.clearCount) countReg <= '0;
    else if (step)            countReg <= countNext;
  end

  assign countVal = countReg;

  // R2/R10: no tick and no restart means the count holds
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.countTick && !strb.clearCount) |=> $stable(countReg));

  // R10: a restart strobe leaves the counter at zero
  p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearCount |=> (countReg == '0));

  // R7: free-run steps by exactly one, modulo the width
  p_free_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (step && strb.freeRun) |=> (countReg == CNT_W'($past(countReg) + 1'b1)));

  // R8: restart mode returns to zero after compare 1
  p_restart_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (step && !strb.freeRun && countReg == cmpVals[0]) |=> (countReg == '0));

endmodule

// File: rtl/cmpTimer.sv
module cmpTimer
  import cmpTimerPkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickPeriph,
  input  logic        tickHigh,
  input  logic        tickSlow,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [3:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        irqOut
);

  dpStrobes_t                    strb;
  logic [PRESC_W-1:0]            prescaleVal;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmpVals;
  logic [NUM_CMP-1:0]            cmpHit;
  logic                          rollHit;
  logic [CNT_W-1:0]              countVal;

  cmpTimerCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .tickPeriph(tickPeriph), .tickHigh(tickHigh), .tickSlow(tickSlow),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut),
    .strb(strb), .prescaleVal(prescaleVal), .cmpVals(cmpVals),
    .cmpHit(cmpHit), .rollHit(rollHit), .countVal(countVal)
  );

  cmpTimerDatapath #(.CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .prescaleVal(prescaleVal),
    .cmpVals(cmpVals), .countVal(countVal), .cmpHit(cmpHit), .rollHit(rollHit)
  );

endmodule

// File: tb/cmpTimer_test.sv
module cmpTimer_test;

  localparam int CLK_PERIOD = 10;
  localparam int CW   = 10;
  localparam logic [31:0] MAXV = (32'd1 << CW) - 1;

  localparam logic [31:0] EN = 32'h1, ENMOD = 32'h2, FRR = 32'h200, SWR = 32'h8000;
  localparam logic [31:0] S001 = 32'h40, S010 = 32'h80, S100 = 32'h100, S011 = 32'hC0;

  logic clk = 0, rstN = 0;
  logic tickPeriph = 0, tickHigh = 0, tickSlow = 0;
  logic busSel = 0, busWrite = 0;
  logic [3:0] busAddr = 0;
  logic [31:0] busWdata = 0;
  logic [31:0] busRdata;
  logic irqOut;

  int nTests = 0, nFails = 0;
  bit finished = 0;

  cmpTimer #(.CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .tickPeriph(tickPeriph), .tickHigh(tickHigh),
    .tickSlow(tickSlow), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int expCount(input int n, input int p);
    return n / (p + 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = 4'(idx); busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    busAddr = 4'(idx);
    #1;
    d = busRdata;
  endtask

  task automatic chkReg(input string req, input int idx, input logic [31:0] exp);
    logic [31:0] v;
    rd(idx, v);
    check(req, v, exp);
  endtask

  // which: bit0 periph, bit1 high, bit2 slow
  task automatic tick(input logic [2:0] which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tickPeriph = which[0]; tickHigh = which[1]; tickSlow = which[2];
      @(negedge clk);
      tickPeriph = 0; tickHigh = 0; tickSlow = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R12 hardware reset values
    chkReg("R12 ctrl", 0, 0);
    chkReg("R12 presc", 1, 0);
    chkReg("R12 status", 2, 0);
    chkReg("R12 ien", 3, 0);
    for (int i = 4; i < 7; i++) chkReg("R12 cmp", i, MAXV);
    chkReg("R12 count", 9, 0);
    check("R5 irq reset", {31'd0, irqOut}, 0);

    // R11 masked control bits
    wr(0, 32'h7FFF_7FFE);
    chkReg("R11 ctrl mask", 0, 32'h7FFF_03EA);

    // R1 unmapped and capture
    wr(12, 32'hFFFF_FFFF);
    chkReg("R1 unmapped read", 12, 0);
    chkReg("R1 unmapped write ignored", 0, 32'h7FFF_03EA);
    chkReg("R1 idx15", 15, 0);
    wr(7, 32'h55); wr(8, 32'hAA);
    chkReg("R1 cap1", 7, 0);
    chkReg("R1 cap2", 8, 0);

    // R3 prescaler width
    wr(1, 32'hFFFF_F003);
    chkReg("R3 presc width", 1, 32'h003);
    wr(1, 0);

    // R2 clock source selection
    wr(0, SWR);
    wr(0, EN | ENMOD | FRR | S001);
    chkReg("R10 restart on enable", 9, 0);
    tick(3'b001, 5); tick(3'b010, 3);
    chkReg("R2 periph source", 9, 5);
    wr(0, EN | ENMOD | FRR | S010);
    tick(3'b001, 2); tick(3'b010, 4);
    chkReg("R2 high source", 9, 9);
    wr(0, EN | ENMOD | FRR | S100);
    tick(3'b011, 3); tick(3'b100, 2);
    chkReg("R2 slow source", 9, 11);
    wr(0, EN | FRR | S011);
    tick(3'b111, 4);
    chkReg("R2 undefined code holds", 9, 11);
    wr(0, EN | FRR);
    tick(3'b111, 2);
    chkReg("R2 no source holds", 9, 11);

    // R3 random prescaler and tick patterns
    for (int t = 0; t < 16; t++) begin
      int p, n, sel;
      logic [2:0] mask;
      logic [31:0] src;
      p = $urandom_range(0, 5);
      n = $urandom_range(0, 30);
      sel = $urandom_range(0, 2);
      mask = 3'(1 << sel);
      src = (sel == 0) ? S001 : (sel == 1) ? S010 : S100;
      wr(0, FRR | src);
      wr(1, 32'(p));
      wr(0, EN | ENMOD | FRR | src);
      for (int i = 0; i < n; i++) begin
        logic [2:0] noise;
        noise = 3'($urandom_range(0, 7)) & ~mask;
        tick(mask | noise, 1);
        repeat ($urandom_range(0, 2)) begin
          tick(noise & ~mask, 1);
        end
      end
      chkReg("R3 prescaled count", 9, 32'(expCount(n, p)));
    end

    // R6 compare flags, R5 irq, R4 write-one-to-clear
    wr(0, SWR);
    wr(0, EN | ENMOD | FRR | S001);
    wr(5, 5); wr(6, 8);
    tick(3'b001, 5);
    chkReg("R6 cmp2 flag", 2, 32'h02);
    check("R5 irq masked", {31'd0, irqOut}, 0);
    wr(3, 32'hFFFF_FFC2);
    chkReg("R5 ien width", 3, 32'h02);
    check("R5 irq raised", {31'd0, irqOut}, 1);
    tick(3'b001, 2);
    chkReg("R6 cmp3 not early", 2, 32'h02);
    tick(3'b001, 1);
    chkReg("R6 cmp3 at match", 2, 32'h06);
    wr(0, FRR | S001);
    check("R5 irq off when disabled", {31'd0, irqOut}, 0);
    wr(0, EN | FRR | S001);
    check("R5 irq back on", {31'd0, irqOut}, 1);
    chkReg("R10 resume without enable-mode", 9, 8);
    wr(2, 32'h39);
    chkReg("R4 unwritten flags kept", 2, 32'h06);
    wr(2, 32'h02);
    chkReg("R4 cmp2 cleared", 2, 32'h04);
    check("R5 irq follows status", {31'd0, irqOut}, 0);
    wr(2, 32'h04);
    chkReg("R4 all clear", 2, 0);

    // R7 rollover in free-run mode
    wr(0, SWR);
    wr(5, 0);
    wr(0, EN | ENMOD | FRR | S001);
    tick(3'b001, int'(MAXV));
    chkReg("R7 count at max", 9, MAXV);
    chkReg("R6 cmp1/cmp3 at max", 2, 32'h05);
    wr(2, 32'h3F);
    tick(3'b001, 1);
    chkReg("R7 wrapped", 9, 0);
    chkReg("R7 rollover flag", 2, 32'h22);
    wr(3, 32'h20);
    check("R7 rollover irq", {31'd0, irqOut}, 1);

    // R8 restart mode
    wr(0, SWR);
    wr(0, EN | ENMOD | S001);
    tick(3'b001, 2);
    wr(4, 4);
    chkReg("R9 cmp1 write restarts", 9, 0);
    tick(3'b001, 4);
    chkReg("R8 reached period", 9, 4);
    chkReg("R8 cmp1 flag", 2, 32'h01);
    tick(3'b001, 1);
    chkReg("R8 back to zero", 9, 0);
    chkReg("R8 no rollover flag", 2, 32'h01);
    tick(3'b001, 3);
    chkReg("R8 counting again", 9, 3);

    // R9 prescaler phase cleared by cmp1 write
    wr(1, 1);
    tick(3'b001, 1);
    wr(4, 6);
    tick(3'b001, 1);
    chkReg("R9 phase cleared", 9, 0);
    tick(3'b001, 1);
    chkReg("R9 first step", 9, 1);
    wr(0, EN | FRR | S001);
    wr(4, 9);
    chkReg("R9 free-run write keeps count", 9, 1);

    // R10 enable behaviour
    wr(1, 0);
    tick(3'b001, 2);
    chkReg("R10 counting", 9, 3);
    wr(0, FRR | S001);
    tick(3'b001, 3);
    chkReg("R10 hold when disabled", 9, 3);
    wr(0, EN | FRR | S001);
    tick(3'b001, 1);
    chkReg("R10 resume", 9, 4);
    wr(0, FRR | S001);
    wr(0, EN | ENMOD | FRR | S001);
    chkReg("R10 enable-mode restart", 9, 0);

    // R12 soft reset keeps selected control bits
    wr(1, 5); wr(3, 32'h3F); wr(4, 7); wr(5, 3); wr(6, 2);
    tick(3'b001, 6);
    wr(0, 32'h0001_83AB);
    chkReg("R12 ctrl after soft reset", 0, 32'h0001_0380);
    chkReg("R12 presc cleared", 1, 0);
    chkReg("R12 status cleared", 2, 0);
    chkReg("R12 ien cleared", 3, 0);
    chkReg("R12 cmp1 ones", 4, MAXV);
    chkReg("R12 cmp2 ones", 5, MAXV);
    chkReg("R12 cmp3 ones", 6, MAXV);
    chkReg("R12 count cleared", 9, 0);
    check("R12 irq low", {31'd0, irqOut}, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule